// File: doc/BRIEF.md
# Indirect-indexed coprocessor register bank

This block holds the register state of a custom-instruction coprocessor. Software sees four 32-bit registers through a small read/write register port. Register 0 holds an index. Register 1 is a data window: reads and writes to it go to the entry of an internal array chosen by the low bits of that index. Registers 2 and 3 are plain scratch storage. With the window, the two-register pair reaches an array larger than the four directly visible registers. Every register is open to every privilege level, and the block does no privilege checking.

The bank also keeps a command register. A three-register custom instruction loads it through a separate write port. Its value chooses the function that the operand-only five-register instruction applies to its four source operands. The chosen function is computed here and returned to the datapath in the same cycle.

Top module: `copro_reg_bank`

## Requirements
- R1: After a synchronous active-high reset, all four visible registers, every array entry and the command register read zero. `cmd_o` is 0, which selects the AND function.
- R2: A write to address 0 (index) stores the full 32-bit value, and reading address 0 returns it. Writing the index never changes any array entry.
- R3: A read of address 1 (window) returns, in the same cycle and without a clock edge, the array entry selected by the current index.
- R4: A write to address 1 updates the selected entry at the next rising clock edge. All other entries keep their values.
- R5: Only index bits [3:0] choose one of the 16 array entries. Higher index bits have no effect on the selection.
- R6: Addresses 2 and 3 are independent 32-bit scratch registers. Writing one changes neither the other, the index nor the array.
- R7: When `cmd_we` is high, `cmd_o` takes `cmd_wdata[1:0]` at the next rising edge, and higher command bits are ignored. When `cmd_we` is low, `cmd_o` holds its value.
- R8: `r5_res` is combinational in the four operands and the command. Command 0 gives AND of all four operands, 1 gives OR, 2 gives XOR, and 3 gives their 32-bit sum modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address: 0 index, 1 window, 2 and 3 scratch |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Combinational read data for `csr_addr` |
| cmd_we | input | 1 | Command write strobe from the three-register instruction |
| cmd_wdata | input | 32 | Command value; bits [1:0] are used |
| cmd_o | output | 2 | Current command to the datapath |
| r5_a | input | 32 | First five-register operand |
| r5_b | input | 32 | Second five-register operand |
| r5_c | input | 32 | Third five-register operand |
| r5_d | input | 32 | Fourth five-register operand |
| r5_res | output | 32 | Result of the commanded function |

## Verification
A wrong internal state shows up at the ports in one of three ways. A corrupted index shows up in the same cycle as the wrong window value. A misdirected window write becomes visible only when software later points the index at the damaged entry. So the bench fills all sixteen entries first and then sweeps the whole array, instead of reading each entry back just after writing it. A stale or mis-decoded command changes `r5_res` on the cycle after the command write. Each function is therefore checked with operands on which all four functions give different results.

// File: rtl/copro_pkg.sv
package copro_pkg;

   localparam int unsigned CSR_ADDR_W = 2;
   localparam int unsigned FUNC_W     = 2;

   typedef enum logic [CSR_ADDR_W-1:0] {
      CSR_INDEX  = 2'd0,
      CSR_WINDOW = 2'd1,
      CSR_SCR0   = 2'd2,
      CSR_SCR1   = 2'd3
   } csr_sel_e;

   typedef enum logic [FUNC_W-1:0] {
      R5_AND = 2'd0,
      R5_OR  = 2'd1,
      R5_XOR = 2'd2,
      R5_ADD = 2'd3
   } r5_func_e;

endpackage

// File: rtl/copro_ind_array.sv
module copro_ind_array
   import copro_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("copro_ind_array: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] entry_q [DEPTH];
   logic [DEPTH-1:0]  hit;

   // one-hot write decode, one comparator per entry
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_dec
         assign hit[g] = we_i && (sel_i == SEL_W'(g));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) entry_q[i] <= wdata_i;
         end
      end
   end

   assign rdata_o = entry_q[sel_i];

   AST_WINDOW_WRITE: assert property (@(posedge clk) disable iff (rst)
      we_i |=> entry_q[$past(sel_i)] == $past(wdata_i)); // R4

   AST_ENTRY_KEEP: assert property (@(posedge clk) disable iff (rst)
      !we_i |=> entry_q[$past(sel_i)] == $past(entry_q[sel_i])); // R2

   AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit)); // R4

endmodule

// File: rtl/copro_csr_regs.sv
module copro_csr_regs
   import copro_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEL_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  we_i,
   input  logic [CSR_ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [SEL_W-1:0]      sel_o,
   output logic                  win_we_o,
   input  logic [DATA_W-1:0]     win_rdata_i,
   output logic [DATA_W-1:0]     rdata_o
);

   localparam int unsigned N_SCR = 2;

   generate
      if (SEL_W > DATA_W) begin : g_bad_sel
         $error("copro_csr_regs: index select wider than data");
      end
   endgenerate

   csr_sel_e          addr_e;
   logic [DATA_W-1:0] index_q;
   logic [DATA_W-1:0] scr_q [N_SCR];
   logic [N_SCR-1:0]  scr_we;

   assign addr_e = csr_sel_e'(addr_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         index_q <= '0;
      end else if (we_i && addr_e == CSR_INDEX) begin
         index_q <= wdata_i;
      end
   end

   generate
      for (genvar s = 0; s < N_SCR; s++) begin : g_scr
         assign scr_we[s] = we_i && (addr_i == CSR_ADDR_W'(int'(CSR_SCR0) + s));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < N_SCR; s++) scr_q[s] <= '0;
      end else begin
         for (int s = 0; s < N_SCR; s++) begin
            if (scr_we[s]) scr_q[s] <= wdata_i;
         end
      end
   end

   assign sel_o    = index_q[SEL_W-1:0];
   assign win_we_o = we_i && (addr_e == CSR_WINDOW);

   always_comb begin
      unique case (addr_e)
         CSR_INDEX:  rdata_o = index_q;
         CSR_WINDOW: rdata_o = win_rdata_i;
         CSR_SCR0:   rdata_o = scr_q[0];
         CSR_SCR1:   rdata_o = scr_q[1];
         default:    rdata_o = '0;
      endcase
   end

   AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
      (we_i && addr_i == CSR_INDEX) |=> index_q == $past(wdata_i)); // R2

   AST_INDEX_KEEP: assert property (@(posedge clk) disable iff (rst)
      !(we_i && addr_i == CSR_INDEX) |=> $stable(index_q)); // R6

   AST_SCR0_KEEP: assert property (@(posedge clk) disable iff (rst)
      !(we_i && addr_i == CSR_SCR0) |=> $stable(scr_q[0])); // R6

   AST_SCR1_KEEP: assert property (@(posedge clk) disable iff (rst)
      !(we_i && addr_i == CSR_SCR1) |=> $stable(scr_q[1])); // R6

   AST_WIN_EXCL: assert property (@(posedge clk) disable iff (rst)
      win_we_o |-> scr_we == '0); // R6

endmodule

// File: rtl/copro_cmd_reg.sv
module copro_cmd_reg
   import copro_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output r5_func_e          func_o
);

   generate
      if (DATA_W < FUNC_W) begin : g_bad_w
         $error("copro_cmd_reg: data narrower than command field");
      end
   endgenerate

   r5_func_e func_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         func_q <= R5_AND;
      end else if (we_i) begin
         func_q <= r5_func_e'(wdata_i[FUNC_W-1:0]);
      end
   end

   assign func_o = func_q;

   AST_CMD_LOAD: assert property (@(posedge clk) disable iff (rst)
      we_i |=> func_o == $past(wdata_i[FUNC_W-1:0])); // R7

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !we_i |=> $stable(func_o)); // R7

endmodule

// File: rtl/copro_r5_alu.sv
module copro_r5_alu
   import copro_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter bit          SUM_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  r5_func_e          func_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] c_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] res_o
);

   logic [DATA_W-1:0] sum;

   // adder shape: balanced pair of adders or a serial chain
   generate
      if (SUM_TREE) begin : g_tree
         logic [DATA_W-1:0] sum_ab, sum_cd;
         assign sum_ab = a_i + b_i;
         assign sum_cd = c_i + d_i;
         assign sum    = sum_ab + sum_cd;
      end else begin : g_chain
         logic [DATA_W-1:0] sum_ab, sum_abc;
         assign sum_ab  = a_i + b_i;
         assign sum_abc = sum_ab + c_i;
         assign sum     = sum_abc + d_i;
      end
   endgenerate

   always_comb begin
      unique case (func_i)
         R5_AND:  res_o = a_i & b_i & c_i & d_i;
         R5_OR:   res_o = a_i | b_i | c_i | d_i;
         R5_XOR:  res_o = a_i ^ b_i ^ c_i ^ d_i;
         R5_ADD:  res_o = sum;
         default: res_o = '0;
      endcase
   end

   AST_AND_SUBSET: assert property (@(posedge clk) disable iff (rst)
      func_i == R5_AND |-> (res_o & ~(a_i & d_i)) == '0); // R8

   AST_OR_COVER: assert property (@(posedge clk) disable iff (rst)
      func_i == R5_OR |-> ((a_i | c_i) & ~res_o) == '0); // R8

   AST_XOR_PARITY: assert property (@(posedge clk) disable iff (rst)
      func_i == R5_XOR |-> ($countones({a_i, b_i, c_i, d_i}) % 2) == ($countones(res_o) % 2)); // R8

endmodule

// File: rtl/copro_reg_bank.sv
module copro_reg_bank
   import copro_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ARR_DEPTH = 16,
   parameter bit          SUM_TREE  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  csr_we,
   input  logic [CSR_ADDR_W-1:0] csr_addr,
   input  logic [DATA_W-1:0]     csr_wdata,
   output logic [DATA_W-1:0]     csr_rdata,
   input  logic                  cmd_we,
   input  logic [DATA_W-1:0]     cmd_wdata,
   output logic [FUNC_W-1:0]     cmd_o,
   input  logic [DATA_W-1:0]     r5_a,
   input  logic [DATA_W-1:0]     r5_b,
   input  logic [DATA_W-1:0]     r5_c,
   input  logic [DATA_W-1:0]     r5_d,
   output logic [DATA_W-1:0]     r5_res
);

   localparam int unsigned SEL_W = $clog2(ARR_DEPTH);

   generate
      if (DATA_W < 8 || SEL_W > DATA_W) begin : g_bad_cfg
         $error("copro_reg_bank: unsupported width or depth");
      end
   endgenerate

   logic [SEL_W-1:0]  sel;
   logic              win_we;
   logic [DATA_W-1:0] win_rdata;
   r5_func_e          func;

   copro_csr_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) regs_i (
      .clk         (clk),
      .rst         (rst),
      .we_i        (csr_we),
      .addr_i      (csr_addr),
      .wdata_i     (csr_wdata),
      .sel_o       (sel),
      .win_we_o    (win_we),
      .win_rdata_i (win_rdata),
      .rdata_o     (csr_rdata)
   );

   copro_ind_array #(.DATA_W(DATA_W), .DEPTH(ARR_DEPTH)) array_i (
      .clk     (clk),
      .rst     (rst),
      .sel_i   (sel),
      .we_i    (win_we),
      .wdata_i (csr_wdata),
      .rdata_o (win_rdata)
   );

   copro_cmd_reg #(.DATA_W(DATA_W)) cmd_i (
      .clk     (clk),
      .rst     (rst),
      .we_i    (cmd_we),
      .wdata_i (cmd_wdata),
      .func_o  (func)
   );

   copro_r5_alu #(.DATA_W(DATA_W), .SUM_TREE(SUM_TREE)) alu_i (
      .clk    (clk),
      .rst    (rst),
      .func_i (func),
      .a_i    (r5_a),
      .b_i    (r5_b),
      .c_i    (r5_c),
      .d_i    (r5_d),
      .res_o  (r5_res)
   );

   assign cmd_o = func;

   AST_RESET_CMD: assert property (@(posedge clk)
      rst |=> cmd_o == FUNC_W'(0)); // R1

   AST_RESET_INDEX: assert property (@(posedge clk)
      (rst && !csr_we) |=> (csr_addr != CSR_INDEX) || (csr_rdata == '0)); // R1

endmodule

// File: tb/copro_reg_bank_tb_top.sv
`timescale 1ns/1ps
module copro_reg_bank_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        csr_we = 1'b0;
   logic [1:0]  csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        cmd_we = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [1:0]  cmd_o;
   logic [31:0] r5_a = '0, r5_b = '0, r5_c = '0, r5_d = '0;
   logic [31:0] r5_res;

   always #2 clk = ~clk;

   copro_reg_bank dut_i (
      .clk(clk), .rst(rst),
      .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_o(cmd_o),
      .r5_a(r5_a), .r5_b(r5_b), .r5_c(r5_c), .r5_d(r5_d), .r5_res(r5_res)
   );

   // scoreboard: 0 = csr_rdata, 1 = r5_res, 2 = cmd_o
   int          kind_q[$];
   logic [31:0] exp_q[$];
   string       req_q[$];
   logic        chk = 1'b0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always @(negedge clk) begin
      if (chk && kind_q.size() > 0) begin
         int          k;
         logic [31:0] e, act;
         string       r;
         k = kind_q.pop_front();
         e = exp_q.pop_front();
         r = req_q.pop_front();
         act = (k == 0) ? csr_rdata : (k == 1) ? r5_res : {30'd0, cmd_o};
         checks++;
         if (act !== e) begin
            errors++;
            $display("FAIL %s kind %0d actual %08h expected %08h", r, k, act, e);
         end
      end
   end

   function automatic logic [31:0] pat(int k);
      return 32'h9E37_79B9 * (k + 1);
   endfunction

   function automatic logic [31:0] model(int f, logic [31:0] a, logic [31:0] b,
                                         logic [31:0] c, logic [31:0] d);
      case (f)
         0: return a & b & c & d;
         1: return a | b | c | d;
         2: return a ^ b ^ c ^ d;
         default: return a + b + c + d;
      endcase
   endfunction

   task automatic step_begin();
      @(posedge clk); #1;
      csr_we = 1'b0; cmd_we = 1'b0; chk = 1'b0;
   endtask

   task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
      step_begin();
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
   endtask

   task automatic cmd_wr(input logic [31:0] d);
      step_begin();
      cmd_we = 1'b1; cmd_wdata = d;
   endtask

   task automatic csr_rd(input logic [1:0] a, input logic [31:0] e, input string r);
      step_begin();
      csr_addr = a;
      kind_q.push_back(0); exp_q.push_back(e); req_q.push_back(r);
      chk = 1'b1;
   endtask

   task automatic cmd_chk(input logic [1:0] e, input string r);
      step_begin();
      kind_q.push_back(2); exp_q.push_back({30'd0, e}); req_q.push_back(r);
      chk = 1'b1;
   endtask

   task automatic res_chk(input int f, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] d, input string r);
      step_begin();
      r5_a = a; r5_b = b; r5_c = c; r5_d = d;
      kind_q.push_back(1); exp_q.push_back(model(f, a, b, c, d)); req_q.push_back(r);
      chk = 1'b1;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R1: reset state of all registers, one entry and the command
      for (int a = 0; a < 4; a++) csr_rd(2'(a), 32'h0, "R1");
      cmd_chk(2'd0, "R1");

      // fill the array through the window
      for (int k = 0; k < 16; k++) begin
         csr_wr(2'd0, 32'(k));
         csr_wr(2'd1, pat(k));
      end
      // R3/R4: sweep all entries afterwards
      for (int k = 0; k < 16; k++) begin
         csr_wr(2'd0, 32'(k));
         csr_rd(2'd1, pat(k), "R3");
      end

      // R5: upper index bits ignored; R2: full index read back
      csr_wr(2'd0, 32'hFFFF_FFF5);
      csr_rd(2'd1, pat(5), "R5");
      csr_rd(2'd0, 32'hFFFF_FFF5, "R2");
      csr_wr(2'd0, 32'h0000_0A3C);
      csr_rd(2'd1, pat(12), "R5");

      // R4: overwrite entry 7, neighbours untouched
      csr_wr(2'd0, 32'd7);
      csr_wr(2'd1, 32'hDEAD_BEEF);
      csr_rd(2'd1, 32'hDEAD_BEEF, "R4");
      csr_wr(2'd0, 32'd6);
      csr_rd(2'd1, pat(6), "R4");
      csr_wr(2'd0, 32'd8);
      csr_rd(2'd1, pat(8), "R4");

      // R2: index writes alone leave every entry intact
      csr_wr(2'd0, 32'd3);
      csr_wr(2'd0, 32'd4);
      csr_wr(2'd0, 32'd3);
      csr_rd(2'd1, pat(3), "R2");

      // R6: scratch registers independent
      csr_wr(2'd2, 32'h1234_5678);
      csr_wr(2'd3, 32'h8765_4321);
      csr_rd(2'd2, 32'h1234_5678, "R6");
      csr_rd(2'd3, 32'h8765_4321, "R6");
      csr_rd(2'd0, 32'd3, "R6");
      csr_rd(2'd1, pat(3), "R6");
      csr_wr(2'd2, 32'h0F0F_0F0F);
      csr_rd(2'd3, 32'h8765_4321, "R6");

      // R7/R8: each command value, two operand sets
      for (int f = 0; f < 4; f++) begin
         cmd_wr(32'(f));
         cmd_chk(2'(f), "R7");
         res_chk(f, 32'hF0F0_FFFF, 32'hFF00_F0F0, 32'hFFF0_0F0F, 32'hFFFF_3C3C, "R8");
         res_chk(f, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, "R8");
      end
      // R7: upper command bits ignored, value held without a write
      cmd_wr(32'hFFFF_FFFD);
      cmd_chk(2'd1, "R7");
      cmd_chk(2'd1, "R7");
      res_chk(1, 32'h0000_0011, 32'h0000_0220, 32'h0000_4400, 32'h0008_0000, "R8");
      cmd_wr(32'h0000_0100);
      res_chk(0, 32'hFFFF_FFFF, 32'hFFFF_00FF, 32'hF0FF_FFFF, 32'hFFFF_FFF3, "R8");

      step_begin();
      @(posedge clk); #1;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule